// File: doc/BRIEF.md
# ADC Sample Extreme Tracker

This block watches three signed 16-bit sample streams (port 1, port 2 and the reference receiver) and keeps, per stream, the smallest and the largest sample accepted since the last clear. A clear command puts every stored minimum at the most positive code and every stored maximum at the most negative code. After a clear, the first accepted sample becomes both the minimum and the maximum.

Software reads the six limits as a burst of 16-bit words through a serial slave. A start pulse copies all six limits into a snapshot and points the word index at the first word. Each read pulse then advances to the next word. The snapshot does not change while sampling continues, so one burst always returns values from a single instant. The six stored limits are also driven out continuously for the neighbouring logic.

Top module: `adc_limit_tracker`

## Requirements
- R1: While rst_n is low, and after it, every minimum output reads 0x7FFF, every maximum output reads 0x8000, the read index is 0 and rd_word_o reads 0x7FFF (the snapshot holds the reset extremes).
- R2: In a cycle with smp_valid_i high and clr_i low, a channel's minimum takes the sample if the sample is smaller. The new value is visible at the output one clock after that edge.
- R3: In a cycle with smp_valid_i high and clr_i low, a channel's maximum takes the sample if the sample is larger. The new value is visible one clock after that edge.
- R4: Comparisons treat samples as two's-complement. 0x8000 (-32768) is the smallest code, 0x7FFF the largest, and 0xFFFF (-1) is below 0x0000.
- R5: When smp_valid_i is low, no stored limit changes, whatever the sample buses carry.
- R6: clr_i sets every minimum to 0x7FFF and every maximum to 0x8000 on the next edge. If smp_valid_i is high in the same cycle, the clear wins and that sample is discarded.
- R7: The three channels are tracked independently. A sample on one bus never moves another channel's limits.
- R8: rd_start_i copies the six limits, as they stand before that edge, into the snapshot and sets the word index to 0. rd_word_o shows word 0 one clock later.
- R9: The word order by index is: 0 port 1 min, 1 port 1 max, 2 port 2 min, 3 port 2 max, 4 reference min, 5 reference max. Each rd_next_i pulse advances the index by one, and the new word is visible one clock later.
- R10: Once the index is 5, further rd_next_i pulses leave it at 5.
- R11: Samples and clears do not change the snapshot. rd_word_o changes only through rd_start_i or rd_next_i.
- R12: If rd_start_i and rd_next_i are high in the same cycle, the start takes effect and the index becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid_i | input | 1 | All three sample buses carry a sample this cycle |
| p1_smp_i | input | 16 | Port 1 sample, signed |
| p2_smp_i | input | 16 | Port 2 sample, signed |
| ref_smp_i | input | 16 | Reference sample, signed |
| clr_i | input | 1 | Clear command pulse: return all limits to their initial extremes |
| rd_start_i | input | 1 | Start of a read burst: take snapshot, index to 0 |
| rd_next_i | input | 1 | Advance to the next word of the burst |
| rd_word_o | output | 16 | Snapshot word at the current index |
| p1_min_o | output | 16 | Port 1 stored minimum |
| p1_max_o | output | 16 | Port 1 stored maximum |
| p2_min_o | output | 16 | Port 2 stored minimum |
| p2_max_o | output | 16 | Port 2 stored maximum |
| ref_min_o | output | 16 | Reference stored minimum |
| ref_max_o | output | 16 | Reference stored maximum |

## Verification
Every result is due exactly one clock after the edge on which its stimulus is taken. This holds for limit updates, clears, snapshot captures and index moves, since each passes through one register and the word mux after the index is combinational. The bench drives inputs on the falling edge and updates its arithmetic model at the rising edge. At the next falling edge it compares all six limits and the read word against that model. The snapshot in the model is taken from the limits as they stood before the capturing edge, which matches the one-register delay.

// File: rtl/lim_pkg.sv
package lim_pkg;
  localparam int LIM_SMP_W   = 16;
  localparam int LIM_NUM_CH  = 3;
  localparam int LIM_WORDS   = 2 * LIM_NUM_CH;
  localparam int LIM_IDX_W   = $clog2(LIM_WORDS);

  // channel slots; word 2*c is the minimum of channel c, word 2*c+1 its maximum
  localparam int CH_PORT1 = 0;
  localparam int CH_PORT2 = 1;
  localparam int CH_REF   = 2;

  typedef enum logic [1:0] {
    UPD_HOLD  = 2'd0,
    UPD_CLEAR = 2'd1,
    UPD_TRACK = 2'd2
  } upd_mode_e;
endpackage

// File: rtl/lim_chan_track.sv
module lim_chan_track
  import lim_pkg::*;
#(
  parameter int W = LIM_SMP_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid_i,
  input  logic         clr_i,
  input  logic [W-1:0] smp_i,
  output logic [W-1:0] min_o,
  output logic [W-1:0] max_o
);
  localparam logic [W-1:0] POS_EXT = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_EXT = {1'b1, {(W-1){1'b0}}};

  upd_mode_e    mode;
  logic [W-1:0] min_q, min_d;
  logic [W-1:0] max_q, max_d;
  logic         min_en, max_en;
  logic         below, above;

  always_comb begin
    if (clr_i)        mode = UPD_CLEAR;
    else if (valid_i) mode = UPD_TRACK;
    else              mode = UPD_HOLD;
  end

  assign below = $signed(smp_i) < $signed(min_q);
  assign above = $signed(smp_i) > $signed(max_q);

  always_comb begin
    min_d  = min_q;
    max_d  = max_q;
    min_en = 1'b0;
    max_en = 1'b0;
    unique case (mode)
      UPD_CLEAR: begin
        min_d  = POS_EXT;
        max_d  = NEG_EXT;
        min_en = 1'b1;
        max_en = 1'b1;
      end
      UPD_TRACK: begin
        min_d  = smp_i;
        max_d  = smp_i;
        min_en = below;
        max_en = above;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min_q <= POS_EXT;
      max_q <= NEG_EXT;
    end else begin
      if (min_en) min_q <= min_d;
      if (max_en) max_q <= max_d;
    end
  end

  assign min_o = min_q;
  assign max_o = max_q;

  // R6
  clear_extremes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (min_o == POS_EXT) && (max_o == NEG_EXT));
  // R2
  min_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !clr_i) |=> ($signed(min_o) <= $signed($past(smp_i))));
  // R3
  max_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !clr_i) |=> ($signed(max_o) >= $signed($past(smp_i))));
  // R2
  min_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ($signed(min_o) <= $signed($past(min_o))));
  // R3
  max_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ($signed(max_o) >= $signed($past(max_o))));
  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_i && !clr_i) |=> ($stable(min_o) && $stable(max_o)));
endmodule

// File: rtl/lim_read_seq.sv
module lim_read_seq
  import lim_pkg::*;
#(
  parameter int W   = LIM_SMP_W,
  parameter int NCH = LIM_NUM_CH
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 next_i,
  input  logic [2*NCH*W-1:0]   lim_i,
  output logic [W-1:0]         word_o
);
  localparam int NW    = 2 * NCH;
  localparam int IW    = (NW > 1) ? $clog2(NW) : 1;
  localparam logic [IW-1:0] LAST = IW'(NW - 1);
  localparam logic [W-1:0] POS_EXT = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_EXT = {1'b1, {(W-1){1'b0}}};

  logic [NW*W-1:0] snap_q, snap_d, snap_rst;
  logic [IW-1:0]   idx_q, idx_d;
  logic            snap_en, idx_en;

  for (genvar c = 0; c < NCH; c++) begin : g_rst
    assign snap_rst[(2*c)*W   +: W] = POS_EXT;
    assign snap_rst[(2*c+1)*W +: W] = NEG_EXT;
  end

  always_comb begin
    snap_d  = lim_i;
    snap_en = start_i;
    idx_d   = idx_q;
    idx_en  = 1'b0;
    if (start_i) begin
      idx_d  = '0;
      idx_en = 1'b1;
    end else if (next_i && (idx_q != LAST)) begin
      idx_d  = idx_q + 1'b1;
      idx_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= snap_rst;
      idx_q  <= '0;
    end else begin
      if (snap_en) snap_q <= snap_d;
      if (idx_en)  idx_q  <= idx_d;
    end
  end

  always_comb begin
    word_o = snap_q[0 +: W];
    for (int k = 0; k < NW; k++) begin
      if (idx_q == IW'(k)) word_o = snap_q[k*W +: W];
    end
  end

  // R8
  start_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (idx_q == '0));
  // R8
  start_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (snap_q == $past(lim_i)));
  // R10
  index_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST);
  // R11
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(snap_q));
  // R9
  index_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && next_i && (idx_q != LAST)) |=> (idx_q == $past(idx_q) + 1'b1));
endmodule

// File: rtl/adc_limit_tracker.sv
module adc_limit_tracker
  import lim_pkg::*;
#(
  parameter int W = LIM_SMP_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         smp_valid_i,
  input  logic [W-1:0] p1_smp_i,
  input  logic [W-1:0] p2_smp_i,
  input  logic [W-1:0] ref_smp_i,
  input  logic         clr_i,
  input  logic         rd_start_i,
  input  logic         rd_next_i,
  output logic [W-1:0] rd_word_o,
  output logic [W-1:0] p1_min_o,
  output logic [W-1:0] p1_max_o,
  output logic [W-1:0] p2_min_o,
  output logic [W-1:0] p2_max_o,
  output logic [W-1:0] ref_min_o,
  output logic [W-1:0] ref_max_o
);
  localparam int NCH = LIM_NUM_CH;

  logic [NCH*W-1:0]   smp_vec;
  logic [NCH*W-1:0]   min_vec, max_vec;
  logic [2*NCH*W-1:0] lim_vec;

  assign smp_vec[CH_PORT1*W +: W] = p1_smp_i;
  assign smp_vec[CH_PORT2*W +: W] = p2_smp_i;
  assign smp_vec[CH_REF*W   +: W] = ref_smp_i;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    lim_chan_track #(.W(W)) i_track (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid_i (smp_valid_i),
      .clr_i   (clr_i),
      .smp_i   (smp_vec[c*W +: W]),
      .min_o   (min_vec[c*W +: W]),
      .max_o   (max_vec[c*W +: W])
    );
    assign lim_vec[(2*c)*W   +: W] = min_vec[c*W +: W];
    assign lim_vec[(2*c+1)*W +: W] = max_vec[c*W +: W];
  end

  lim_read_seq #(.W(W), .NCH(NCH)) i_read (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (rd_start_i),
    .next_i  (rd_next_i),
    .lim_i   (lim_vec),
    .word_o  (rd_word_o)
  );

  assign p1_min_o  = min_vec[CH_PORT1*W +: W];
  assign p1_max_o  = max_vec[CH_PORT1*W +: W];
  assign p2_min_o  = min_vec[CH_PORT2*W +: W];
  assign p2_max_o  = max_vec[CH_PORT2*W +: W];
  assign ref_min_o = min_vec[CH_REF*W   +: W];
  assign ref_max_o = max_vec[CH_REF*W   +: W];

  // R7
  chan_isolate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid_i && !clr_i && (p1_smp_i == $past(p1_smp_i)) && $stable(p1_min_o))
      |=> ($signed(p1_min_o) <= $signed($past(p1_smp_i))));
  // R4
  signed_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $signed(p1_min_o) <= $signed(p1_max_o) || (p1_min_o == {1'b0, {(W-1){1'b1}}}));
endmodule

// File: tb/test_adc_limit_tracker.sv
module test_adc_limit_tracker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        smp_valid_i, clr_i, rd_start_i, rd_next_i;
  logic [15:0] p1_smp_i, p2_smp_i, ref_smp_i;
  logic [15:0] rd_word_o, p1_min_o, p1_max_o, p2_min_o, p2_max_o, ref_min_o, ref_max_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int mn [3];
  int mx [3];
  int snap [6];
  int idx;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_limit_tracker i_adc_limit_tracker (
    .clk(clk), .rst_n(rst_n), .smp_valid_i(smp_valid_i),
    .p1_smp_i(p1_smp_i), .p2_smp_i(p2_smp_i), .ref_smp_i(ref_smp_i),
    .clr_i(clr_i), .rd_start_i(rd_start_i), .rd_next_i(rd_next_i),
    .rd_word_o(rd_word_o), .p1_min_o(p1_min_o), .p1_max_o(p1_max_o),
    .p2_min_o(p2_min_o), .p2_max_o(p2_max_o), .ref_min_o(ref_min_o),
    .ref_max_o(ref_max_o)
  );

  function automatic int sx(input logic [15:0] v);
    return int'($signed(v));
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " p1 min"},  sx(p1_min_o),  mn[0]);
    chk({tag, " p1 max"},  sx(p1_max_o),  mx[0]);
    chk({tag, " p2 min"},  sx(p2_min_o),  mn[1]);
    chk({tag, " p2 max"},  sx(p2_max_o),  mx[1]);
    chk({tag, " ref min"}, sx(ref_min_o), mn[2]);
    chk({tag, " ref max"}, sx(ref_max_o), mx[2]);
    chk({tag, " word"},    sx(rd_word_o), snap[idx]);
  endtask

  task automatic model_clear();
    for (int c = 0; c < 3; c++) begin
      mn[c] = 32767;
      mx[c] = -32768;
    end
  endtask

  // one cycle: drive at falling edge, model at rising edge, back at falling edge
  task automatic cyc(input bit v, input int a, input int b, input int r,
                     input bit clr, input bit st, input bit nx);
    int s [3];
    smp_valid_i = v; clr_i = clr; rd_start_i = st; rd_next_i = nx;
    p1_smp_i = 16'(a); p2_smp_i = 16'(b); ref_smp_i = 16'(r);
    s[0] = sx(16'(a)); s[1] = sx(16'(b)); s[2] = sx(16'(r));
    @(posedge clk);
    if (st) begin
      for (int c = 0; c < 3; c++) begin
        snap[2*c]   = mn[c];
        snap[2*c+1] = mx[c];
      end
      idx = 0;
    end else if (nx && idx < 5) idx++;
    if (clr) model_clear();
    else if (v) begin
      for (int c = 0; c < 3; c++) begin
        if (s[c] < mn[c]) mn[c] = s[c];
        if (s[c] > mx[c]) mx[c] = s[c];
      end
    end
    @(negedge clk);
    smp_valid_i = 0; clr_i = 0; rd_start_i = 0; rd_next_i = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; smp_valid_i = 0; clr_i = 0; rd_start_i = 0; rd_next_i = 0;
    p1_smp_i = 0; p2_smp_i = 0; ref_smp_i = 0;
    model_clear();
    for (int k = 0; k < 6; k++) snap[k] = (k % 2 == 0) ? 32767 : -32768;
    idx = 0;
    repeat (3) @(negedge clk);
    check_all("R1 in reset");
    rst_n = 1;
    @(negedge clk);
    check_all("R1 after reset");

    // R5: invalid samples change nothing
    cyc(0, -5, 7, 100, 0, 0, 0);
    check_all("R5 idle");

    // R4 sign corners, R2 R3 first sample sets both
    cyc(1, -1, 0, 32767, 0, 0, 0);
    check_all("R2 R3 first sample");
    cyc(1, 0, -1, -32768, 0, 0, 0);
    check_all("R4 signed compare");
    chk("R4 ref min is 0x8000", sx(ref_min_o), -32768);

    // R7: only port 2 moves (others repeat inside their ranges)
    cyc(1, -1, 1000, 0, 0, 0, 0);
    check_all("R7 isolation");

    // R6: clear beats a simultaneous sample
    cyc(1, 123, 456, 789, 1, 0, 0);
    check_all("R6 clear wins");
    chk("R6 p1 min extreme", sx(p1_min_o), 32767);
    cyc(1, 123, 456, 789, 0, 0, 0);
    check_all("R6 next sample applies");

    // near-exhaustive sweep with interleaved reads, idle cycles and clears
    for (int pass = 0; pass < 2; pass++) begin
      model_clear();
      cyc(0, 0, 0, 0, 1, 0, 0);
      check_all("R6 sweep clear");
      for (int k = 0; k < 256; k++) begin
        int kk = (pass == 0) ? k : ((k * 97) % 256);
        int v  = kk * 257 - 32768;
        bit st = (k % 29 == 3);
        bit nx = (k % 3 == 1) || (k % 29 == 3 && k % 2 == 0);
        bit vl = (k % 11 != 5);
        cyc(vl, v, -v - 1, v ^ 16'h5a5a, (k == 200 && pass == 1), st, nx);
        check_all(vl ? "R2 R3 R9 R11 sweep" : "R5 R11 sweep");
      end
    end

    // R8 R9 R10: full burst in order
    cyc(1, -300, 300, 5, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0);
    check_all("R8 start");
    for (int k = 0; k < 7; k++) begin
      cyc(1, 20000 - k, -20000 + k, k, 0, 0, 1);
      check_all(k >= 5 ? "R10 hold last" : "R9 order R11 snapshot");
    end
    chk("R10 index at 5 word", sx(rd_word_o), snap[5]);

    // R12: start and next together
    cyc(0, 0, 0, 0, 0, 1, 1);
    check_all("R12 start wins");
    // R11: clear leaves snapshot
    cyc(0, 0, 0, 0, 1, 0, 0);
    check_all("R11 clear keeps snapshot");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule